// File: doc/BRIEF.md
# Modem Status Loopback Logic

This block holds the modem control byte and the modem status byte of a 16550-style serial controller. No external modem pins are sampled. The four status lines are derived from the control byte alone. When the loop bit is set, the control outputs are turned back into the status inputs. When the loop bit is clear, carrier-detect and data-set-ready are reported as asserted and the other two lines as deasserted.

Each write to the control byte compares the newly derived lines with the lines held before the write. A change sets a sticky delta bit in the low nibble of the status byte. A host read of the status byte returns the value it holds and clears all delta bits on the next clock edge. A change flag, high while any delta bit is set, feeds the controller's interrupt logic.

Top module: `msl_modem_status`

## Requirements
- R1: With loop (control bit 4) set, status bit 4 (CTS) equals control bit 1 (RTS), bit 5 (DSR) equals control bit 0 (DTR), bit 6 (RI) equals control bit 2 (OUT1), and bit 7 (DCD) equals control bit 3 (OUT2).
- R2: With loop clear, status bits 7 (DCD) and 5 (DSR) read 1 and bits 6 (RI) and 4 (CTS) read 0, so the upper nibble is 4'b1010.
- R3: A control write stores only data bits 0 to 4, and bits 5 to 7 of the control readback are always 0.
- R4: A control write that changes CTS, DSR or DCD sets status bit 0 (CTS delta), bit 1 (DSR delta) or bit 3 (DCD delta) respectively, one clock after the write strobe.
- R5: Status bit 2 (ring delta) is set by a control write only when RI goes from 1 to 0; a rising RI or an unchanged RI leaves it as it was.
- R6: Delta bits are sticky: without a status read, a set delta bit stays set across any number of control writes, while the upper nibble follows each write.
- R7: During a status read strobe the status output shows the current value including deltas; one clock later all four delta bits are 0 and the upper nibble is unchanged.
- R8: When a status read and a control write fall in the same cycle, deltas that existed before are cleared and deltas detected by that write are set.
- R9: During and after reset the control readback is 0x00 and the status byte is 0xA0 with the change flag low.
- R10: The change flag is high exactly when at least one of status bits 0 to 3 is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr_en | input | 1 | Control byte write strobe |
| ctl_wr_data | input | 8 | Control byte write data |
| sts_rd_en | input | 1 | Status byte read strobe |
| ctl_q | output | 8 | Control byte readback |
| sts_q | output | 8 | Status byte: lines in bits 7..4, deltas in bits 3..0 |
| chg_flag | output | 1 | High while any delta bit is set |

## Verification
The hardest situation to reach is the ring delta. It needs loop mode with OUT1 raised first, which must not set the delta, and then OUT1 dropped. The vector table walks through that order and also reaches the case where leaving loop mode lowers RI and flips CTS in one write. A directed step puts a read and a write in the same cycle, so that the clear and a newly detected delta meet at the same edge.

// File: rtl/msl_pkg.sv
package msl_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned CTL_W   = 5;
  localparam int unsigned LINE_W  = 4;

  // control byte bit positions
  localparam int unsigned C_DTR  = 0;
  localparam int unsigned C_RTS  = 1;
  localparam int unsigned C_OUT1 = 2;
  localparam int unsigned C_OUT2 = 3;
  localparam int unsigned C_LOOP = 4;

  // status lines, packed to sit in status bits 7..4
  typedef struct packed {
    logic dcd;
    logic ri;
    logic dsr;
    logic cts;
  } line_t;

  // delta flags, packed to sit in status bits 3..0
  typedef struct packed {
    logic d_dcd;
    logic ring_trail;
    logic d_dsr;
    logic d_cts;
  } delta_t;

  localparam line_t IDLE_LINES = '{dcd: 1'b1, ri: 1'b0, dsr: 1'b1, cts: 1'b0};
endpackage

// File: rtl/msl_ctl_reg.sv
module msl_ctl_reg
  import msl_pkg::*;
#(
  parameter int unsigned IN_W   = BYTE_W,
  parameter int unsigned KEEP_W = CTL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IN_W-1:0]   wr_data,
  output logic [KEEP_W-1:0] ctl
);
  logic [KEEP_W-1:0] ctl_nxt;

  always_comb begin
    ctl_nxt = ctl;
    if (wr_en) ctl_nxt = wr_data[KEEP_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl <= '0;
    else        ctl <= ctl_nxt;
  end
endmodule

// File: rtl/msl_line_map.sv
module msl_line_map
  import msl_pkg::*;
#(
  parameter int unsigned KEEP_W = CTL_W
) (
  input  logic [KEEP_W-1:0] ctl,
  output line_t             lines
);
  always_comb begin
    if (ctl[C_LOOP]) begin
      lines.cts = ctl[C_RTS];
      lines.dsr = ctl[C_DTR];
      lines.ri  = ctl[C_OUT1];
      lines.dcd = ctl[C_OUT2];
    end else begin
      lines = IDLE_LINES;
    end
  end
endmodule

// File: rtl/msl_delta_det.sv
module msl_delta_det
  import msl_pkg::*;
(
  input  logic   wr_en,
  input  line_t  old_lines,
  input  line_t  new_lines,
  output delta_t set_mask
);
  always_comb begin
    set_mask = '0;
    if (wr_en) begin
      set_mask.d_cts      = old_lines.cts ^ new_lines.cts;
      set_mask.d_dsr      = old_lines.dsr ^ new_lines.dsr;
      set_mask.d_dcd      = old_lines.dcd ^ new_lines.dcd;
      set_mask.ring_trail = old_lines.ri & ~new_lines.ri;
    end
  end
endmodule

// File: rtl/msl_sts_reg.sv
module msl_sts_reg
  import msl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   wr_en,
  input  logic   rd_en,
  input  line_t  new_lines,
  input  delta_t set_mask,
  output line_t  lines_q,
  output delta_t delta_q
);
  line_t  lines_nxt;
  delta_t delta_nxt;
  delta_t delta_kept;

  always_comb begin
    lines_nxt  = lines_q;
    if (wr_en) lines_nxt = new_lines;
    delta_kept = rd_en ? delta_t'('0) : delta_q;
    delta_nxt  = delta_kept | set_mask;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines_q <= IDLE_LINES;
      delta_q <= '0;
    end else begin
      lines_q <= lines_nxt;
      delta_q <= delta_nxt;
    end
  end
endmodule

// File: rtl/msl_modem_status.sv
module msl_modem_status
  import msl_pkg::*;
#(
  parameter int unsigned DATA_W = BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_wr_en,
  input  logic [DATA_W-1:0] ctl_wr_data,
  input  logic              sts_rd_en,
  output logic [DATA_W-1:0] ctl_q,
  output logic [DATA_W-1:0] sts_q,
  output logic              chg_flag
);
  localparam int unsigned PAD_W = DATA_W - CTL_W;

  logic [CTL_W-1:0] ctl_r;
  logic [CTL_W-1:0] ctl_wr_kept;
  line_t            wr_lines;
  line_t            lines_q;
  delta_t           set_mask;
  delta_t           delta_q;

  assign ctl_wr_kept = ctl_wr_data[CTL_W-1:0];

  msl_ctl_reg #(.IN_W(DATA_W), .KEEP_W(CTL_W)) i_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en),
    .wr_data(ctl_wr_data), .ctl(ctl_r)
  );

  msl_line_map #(.KEEP_W(CTL_W)) i_map (
    .ctl(ctl_wr_kept), .lines(wr_lines)
  );

  msl_delta_det i_det (
    .wr_en(ctl_wr_en), .old_lines(lines_q),
    .new_lines(wr_lines), .set_mask(set_mask)
  );

  msl_sts_reg i_sts (
    .clk(clk), .rst_n(rst_n), .wr_en(ctl_wr_en), .rd_en(sts_rd_en),
    .new_lines(wr_lines), .set_mask(set_mask),
    .lines_q(lines_q), .delta_q(delta_q)
  );

  assign ctl_q    = {{PAD_W{1'b0}}, ctl_r};
  assign sts_q    = {lines_q, delta_q};
  assign chg_flag = |delta_q;
endmodule

// File: rtl/msl_modem_status_chk.sv
module msl_modem_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr_en,
  input logic       sts_rd_en,
  input logic [7:0] ctl_q,
  input logic [7:0] sts_q,
  input logic       chg_flag
);
  a_r1_loop_map: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[4] |-> sts_q[7:4] == {ctl_q[3], ctl_q[2], ctl_q[0], ctl_q[1]});

  a_r2_idle_lines: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_q[4] |-> sts_q[7:4] == 4'b1010);

  a_r3_ctl_mask: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_q[7:5] == 3'b000);

  a_r5_no_rise_teri: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_en && !sts_rd_en && !sts_q[6] && !sts_q[2]) |=> !sts_q[2]);

  a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rd_en |=> (sts_q[3:0] & $past(sts_q[3:0])) == $past(sts_q[3:0]));

  a_r7_read_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd_en && !ctl_wr_en) |=> (sts_q[3:0] == 4'h0 && $stable(sts_q[7:4])));

  a_r10_chg_flag: assert property (@(posedge clk) disable iff (!rst_n)
    chg_flag == (sts_q[3:0] != 4'h0));
endmodule

bind msl_modem_status msl_modem_status_chk i_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .sts_rd_en(sts_rd_en),
  .ctl_q(ctl_q), .sts_q(sts_q), .chg_flag(chg_flag)
);

// File: tb/test_msl_modem_status.sv
module test_msl_modem_status;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 8;
  // each entry: {write data, read after, expected status, expected control}
  localparam logic [31:0] VEC [NVEC] = '{
    {8'h00, 8'h00, 8'hA0, 8'h00},  // R2 idle lines, no change
    {8'h10, 8'h01, 8'h0A, 8'h10},  // R1 R4 enter loop: DSR/DCD drop
    {8'h12, 8'h00, 8'h11, 8'h12},  // R4 CTS rises
    {8'h16, 8'h01, 8'h51, 8'h16},  // R5 R6 RI rises, no ring delta
    {8'h12, 8'h01, 8'h14, 8'h12},  // R5 RI falls sets ring delta
    {8'hFF, 8'h00, 8'hFA, 8'h1F},  // R3 mask, R1 all lines
    {8'h0F, 8'h01, 8'hAF, 8'h0F},  // R6 sticky + R5 + R4 leave loop
    {8'h0F, 8'h00, 8'hA0, 8'h0F}   // R4 no change, no delta
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_wr_en;
  logic [7:0] ctl_wr_data;
  logic       sts_rd_en;
  logic [7:0] ctl_q;
  logic [7:0] sts_q;
  logic       chg_flag;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msl_modem_status i_msl_modem_status (
    .clk(clk), .rst_n(rst_n), .ctl_wr_en(ctl_wr_en), .ctl_wr_data(ctl_wr_data),
    .sts_rd_en(sts_rd_en), .ctl_q(ctl_q), .sts_q(sts_q), .chg_flag(chg_flag)
  );

  task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] d, input logic rd);
    @(negedge clk);
    ctl_wr_en = wr; ctl_wr_data = d; sts_rd_en = rd;
    @(negedge clk);
    ctl_wr_en = 1'b0; sts_rd_en = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; ctl_wr_en = 1'b0; ctl_wr_data = 8'h00; sts_rd_en = 1'b0;
    repeat (3) @(negedge clk);
    // R9 reset state
    check8("R9 status", sts_q, 8'hA0);
    check8("R9 control", ctl_q, 8'h00);
    check8("R9 chg", {7'd0, chg_flag}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    check8("R9 status after release", sts_q, 8'hA0);

    for (int i = 0; i < NVEC; i++) begin
      step(1'b1, VEC[i][31:24], 1'b0);
      check8("R1/R2/R4/R5/R6 status", sts_q, VEC[i][15:8]);
      check8("R3 control", ctl_q, VEC[i][7:0]);
      check8("R10 chg", {7'd0, chg_flag}, {7'd0, VEC[i][11:8] != 4'h0});
      if (VEC[i][16]) begin
        step(1'b0, 8'h00, 1'b1);
        check8("R7 cleared", sts_q, {VEC[i][15:12], 4'h0});
        check8("R10 chg after read", {7'd0, chg_flag}, 8'h00);
      end
    end

    // R8 same-cycle read and write; state ctl=0F, sts=A0
    step(1'b1, 8'h10, 1'b0);
    check8("R8 setup", sts_q, 8'h0A);
    step(1'b1, 8'h12, 1'b1);
    check8("R8 write delta kept, old cleared", sts_q, 8'h11);

    // R7 read shows current value during strobe
    @(negedge clk);
    sts_rd_en = 1'b1;
    #1;
    check8("R7 value during read", sts_q, 8'h11);
    @(negedge clk);
    sts_rd_en = 1'b0;
    check8("R7 clear after read", sts_q, 8'h10);

    // R6 idle cycles keep deltas
    step(1'b1, 8'h13, 1'b0);
    repeat (4) @(negedge clk);
    check8("R6 sticky over idle", sts_q, 8'h32);

    // R9 reset in mid operation
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check8("R9 async reset status", sts_q, 8'hA0);
    check8("R9 async reset control", ctl_q, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule